// File: doc/BRIEF.md
# Dual-Port Collision Arbiter

This block settles contention when two independent memory ports select the same word in the same clock cycle. Each port presents an active-low select, a word address and a write request. When both selects are low and the addresses are equal, the block names one port the loser. That port sees its active-low busy flag driven low and its write request blocked before it reaches the storage array. The busy flags can also feed neighbouring logic, such as a mailbox, that must refuse work from a port while it is blocked.

The winner is the port that has held a steady select and address for longer. Each port keeps a saturating age count of the cycles its access has stayed unchanged. When a collision begins, the port with the larger age wins. Equal ages go to the left port. The verdict is latched for as long as the collision lasts, so the flags cannot flip while the addresses still match. Inputs are assumed to be synchronized already. Flags and write gating are combinational in the current inputs and in state registered on earlier edges.

Top module: `dp_collision_arbiter`

## Requirements
- R1: When either select is high or the two addresses differ, both busy flags are high and neither write inhibit is set.
- R2: When a collision begins and one port has held its select low on an unchanged address for more cycles than the other, the other port's busy flag is low and the long-standing port's flag stays high. The age count saturates, so this still holds after an arbitrarily long steady access.
- R3: When both ports change their access in the same cycle and collide, the right port loses (right busy low, left busy high). The two busy flags are never low together.
- R4: A port that drives its select low onto an address the other port already holds sees its busy flag go low in that same cycle.
- R5: Busy returns high in the cycle the addresses stop matching or in the cycle either select goes high.
- R6: While a port's busy flag is low, its write inhibit is set and its gated write output is 0 even with the write request at 1. The winner's gated write output follows its write request.
- R7: The verdict is frozen for the whole collision. If both ports move together to a new equal address, the same port keeps losing.
- R8: During and straight after reset with idle selects, both busy flags are high and each gated write output follows its write request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_cs_n | input | 1 | Left port select, active low |
| l_addr | input | AW | Left port word address |
| l_wr | input | 1 | Left port write request |
| r_cs_n | input | 1 | Right port select, active low |
| r_addr | input | AW | Right port word address |
| r_wr | input | 1 | Right port write request |
| l_busy_n | output | 1 | Left busy flag, low while left loses a collision |
| r_busy_n | output | 1 | Right busy flag, low while right loses a collision |
| l_wr_inhibit | output | 1 | Left writes blocked this cycle |
| r_wr_inhibit | output | 1 | Right writes blocked this cycle |
| l_wr_go | output | 1 | Left write request after inhibit gating |
| r_wr_go | output | 1 | Right write request after inhibit gating |

## Verification
The hardest case to reach is a collision that continues while both addresses move together. Only there does a latched verdict differ from a fresh one. The stimulus first makes the left port lose by letting the right port settle first. Both ports then jump to a new shared address in the same cycle. A fresh decision would read that as a tie and pick the right port, so a surviving left loss shows the verdict is held. The age counter's saturation is reached by holding one port steady for far longer than its counter range before the other port arrives.

// File: rtl/dp_collision_arbiter.sv
module dp_collision_arbiter #(
  parameter int AW    = 13,
  parameter int AGE_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_cs_n,
  input  logic [AW-1:0] l_addr,
  input  logic          l_wr,
  input  logic          r_cs_n,
  input  logic [AW-1:0] r_addr,
  input  logic          r_wr,
  output logic          l_busy_n,
  output logic          r_busy_n,
  output logic          l_wr_inhibit,
  output logic          r_wr_inhibit,
  output logic          l_wr_go,
  output logic          r_wr_go
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic             l_sel_q, r_sel_q;
  logic [AW-1:0]    l_addr_q, r_addr_q;
  logic [AGE_W-1:0] l_age_q, r_age_q;
  logic             coll_q, lose_l_q;

  wire l_sel = !l_cs_n;
  wire r_sel = !r_cs_n;
  wire l_new = l_sel && (!l_sel_q || l_addr != l_addr_q);
  wire r_new = r_sel && (!r_sel_q || r_addr != r_addr_q);

  wire [AGE_W-1:0] l_age_now = (!l_sel || l_new) ? '0 :
                               (l_age_q == AGE_MAX) ? AGE_MAX : l_age_q + 1'b1;
  wire [AGE_W-1:0] r_age_now = (!r_sel || r_new) ? '0 :
                               (r_age_q == AGE_MAX) ? AGE_MAX : r_age_q + 1'b1;

  wire match  = l_sel && r_sel && (l_addr == r_addr);
  wire lose_l = coll_q ? lose_l_q : (r_age_now > l_age_now);

  assign l_wr_inhibit = match && lose_l;
  assign r_wr_inhibit = match && !lose_l;
  assign l_busy_n     = !l_wr_inhibit;
  assign r_busy_n     = !r_wr_inhibit;
  assign l_wr_go      = l_wr && !l_wr_inhibit;
  assign r_wr_go      = r_wr && !r_wr_inhibit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_sel_q  <= 1'b0;
      r_sel_q  <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      l_age_q  <= '0;
      r_age_q  <= '0;
      coll_q   <= 1'b0;
      lose_l_q <= 1'b0;
    end else begin
      l_sel_q  <= l_sel;
      r_sel_q  <= r_sel;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      l_age_q  <= l_age_now;
      r_age_q  <= r_age_now;
      coll_q   <= match;
      lose_l_q <= lose_l;
    end
  end
endmodule

// File: rtl/dp_collision_arbiter_chk.sv
module dp_collision_arbiter_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_cs_n,
  input logic [AW-1:0] l_addr,
  input logic          r_cs_n,
  input logic [AW-1:0] r_addr,
  input logic          l_busy_n,
  input logic          r_busy_n,
  input logic          l_wr_go,
  input logic          r_wr_go
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  wire hit = !l_cs_n && !r_cs_n && (l_addr == r_addr);

  AST_IDLE_FLAGS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (l_busy_n && r_busy_n)); // R1
  AST_HIT_HAS_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (l_busy_n != r_busy_n)); // R2
  AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n)); // R3
  AST_LEFT_LOSER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !l_busy_n |-> !l_wr_go); // R6
  AST_RIGHT_LOSER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !r_busy_n |-> !r_wr_go); // R6
  AST_VERDICT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && hit && $past(hit) && $past(!l_busy_n)) |-> !l_busy_n); // R7
endmodule

bind dp_collision_arbiter dp_collision_arbiter_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_cs_n(l_cs_n), .l_addr(l_addr), .r_cs_n(r_cs_n), .r_addr(r_addr),
  .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
  .l_wr_go(l_wr_go), .r_wr_go(r_wr_go)
);

// File: tb/dp_collision_arbiter_test.sv
module dp_collision_arbiter_test;
  localparam int AW = 13;
  localparam int NV = 14;

  typedef struct packed {
    logic          lcs;
    logic [AW-1:0] la;
    logic          lw;
    logic          rcs;
    logic [AW-1:0] ra;
    logic          rw;
    logic [3:0]    exp; // {l_busy_n, r_busy_n, l_wr_go, r_wr_go}
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b1, 13'd0, 1'b0, 1'b1, 13'd0, 1'b0, 4'b1100},
    '{1'b0, 13'd5, 1'b1, 1'b1, 13'd5, 1'b1, 4'b1111},
    '{1'b0, 13'd5, 1'b1, 1'b0, 13'd5, 1'b1, 4'b1010},
    '{1'b0, 13'd5, 1'b1, 1'b0, 13'd5, 1'b1, 4'b1010},
    '{1'b0, 13'd5, 1'b1, 1'b0, 13'd6, 1'b1, 4'b1111},
    '{1'b0, 13'd5, 1'b0, 1'b0, 13'd5, 1'b0, 4'b1000},
    '{1'b1, 13'd5, 1'b0, 1'b0, 13'd5, 1'b1, 4'b1101},
    '{1'b0, 13'd5, 1'b1, 1'b0, 13'd5, 1'b1, 4'b0101},
    '{1'b0, 13'd9, 1'b1, 1'b0, 13'd9, 1'b1, 4'b0101},
    '{1'b1, 13'd9, 1'b0, 1'b1, 13'd9, 1'b0, 4'b1100},
    '{1'b0, 13'd3, 1'b1, 1'b0, 13'd3, 1'b1, 4'b1010},
    '{1'b0, 13'd4, 1'b0, 1'b0, 13'd4, 1'b0, 4'b1000},
    '{1'b0, 13'd4, 1'b0, 1'b0, 13'd7, 1'b0, 4'b1100},
    '{1'b0, 13'd7, 1'b1, 1'b0, 13'd7, 1'b1, 4'b0101}
  };
  localparam string TAG [NV] = '{"R1", "R1", "R4", "R2", "R5", "R2", "R5",
                                  "R4", "R7", "R1", "R3", "R7", "R5", "R2"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_cs_n = 1'b1, r_cs_n = 1'b1, l_wr = 1'b0, r_wr = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_n, r_busy_n, l_wr_inhibit, r_wr_inhibit, l_wr_go, r_wr_go;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dp_collision_arbiter #(.AW(AW), .AGE_W(4)) uut (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_addr(l_addr), .l_wr(l_wr),
    .r_cs_n(r_cs_n), .r_addr(r_addr), .r_wr(r_wr),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_wr_inhibit(l_wr_inhibit), .r_wr_inhibit(r_wr_inhibit),
    .l_wr_go(l_wr_go), .r_wr_go(r_wr_go)
  );

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {l_busy_n, r_busy_n, l_wr_go, r_wr_go, l_wr_inhibit, r_wr_inhibit};
  endfunction

  function automatic logic [5:0] expand(input logic [3:0] e);
    return {e, ~e[3], ~e[2]};
  endfunction

  task automatic drive(input logic lc, input logic [AW-1:0] la, input logic lw,
                       input logic rc, input logic [AW-1:0] ra, input logic rw);
    @(negedge clk);
    l_cs_n = lc; l_addr = la; l_wr = lw;
    r_cs_n = rc; r_addr = ra; r_wr = rw;
    #2;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset state with idle selects, writes pass through
    drive(1'b1, 13'd0, 1'b1, 1'b1, 13'd0, 1'b1);
    check("R8", outs(), expand(4'b1111));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 13'd0, 1'b1, 1'b1, 13'd0, 1'b1);
    check("R8", outs(), expand(4'b1111));

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].lcs, VEC[i].la, VEC[i].lw, VEC[i].rcs, VEC[i].ra, VEC[i].rw);
      check(TAG[i], outs(), expand(VEC[i].exp));
    end

    // R2: left steady far beyond the age range, then right arrives
    drive(1'b1, 13'd2, 1'b0, 1'b1, 13'd2, 1'b0);
    for (int i = 0; i < 40; i++) drive(1'b0, 13'd2, 1'b0, 1'b1, 13'd2, 1'b0);
    drive(1'b0, 13'd2, 1'b1, 1'b0, 13'd2, 1'b1);
    check("R2", outs(), expand(4'b1010));
    // R7: long collision keeps the same verdict each cycle
    for (int i = 0; i < 20; i++) begin
      drive(1'b0, 13'd2, 1'b1, 1'b0, 13'd2, 1'b1);
      check("R7", outs(), expand(4'b1010));
    end
    // R6: loser write request blocked, winner request passes
    drive(1'b0, 13'd2, 1'b0, 1'b0, 13'd2, 1'b1);
    check("R6", outs(), expand(4'b1000));
    // R5: right select high releases busy
    drive(1'b0, 13'd2, 1'b1, 1'b1, 13'd2, 1'b1);
    check("R5", outs(), expand(4'b1111));

    // R3: both collide in the first cycle after reset
    drive(1'b1, 13'd11, 1'b0, 1'b1, 13'd11, 1'b0);
    rst_n = 1'b0;
    repeat (2) drive(1'b1, 13'd11, 1'b0, 1'b1, 13'd11, 1'b0);
    rst_n = 1'b1;
    drive(1'b0, 13'd11, 1'b1, 1'b0, 13'd11, 1'b1);
    check("R3", outs(), expand(4'b1010));
    drive(1'b0, 13'd11, 1'b1, 1'b0, 13'd11, 1'b1);
    check("R3", outs(), expand(4'b1010));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule